// File: doc/BRIEF.md
# Grouped Four-Level Interrupt Prioritizer

This block sits beside a small microcontroller core and decides which interrupt request the core services next. Request lines are organised into groups, and every group holds two sources. Two byte-wide priority registers on a simple write/read port give each group a two-bit level. The same bit position in both registers belongs to the same group, with the second register supplying the high bit. This gives four levels, from 0 (lowest) to 3 (highest).

On each evaluation the block takes the pending requests that are enabled and that outrank everything currently in service. It registers an interrupt request towards the core together with the index of the winning source. When two or more requests share a level, a fixed polling order picks one of them. The lower group number wins, and inside a group the first source wins.

A four-bit in-service vector records which levels have been accepted. The core sets a bit with its acknowledge, and a return-from-interrupt pulse clears the highest bit that is set. A request can preempt a running handler only when its level is strictly above every level in service. Detection of edges or levels on external pins is handled elsewhere, and so is the core itself.

Top module: `irq_prioritizer`

## Requirements
- R1: A group's level is {high-priority register bit g, low-priority register bit g}, where g is the group number. 2'b11 is the highest level and 2'b00 is the lowest.
- R2: The low-priority register sits at address 0xA9 and the high-priority register at 0xB9. Writes store bits 5:0 only. Reads return the stored bits, with bits 7:6 reading zero, and any other address reads zero. Both registers reset to zero.
- R3: Among the eligible requests, the one with the highest level is selected.
- R4: Ties within a level go to the lowest group number, then to the first source of the group. The vector index is group*2 + member, so source bit s of the request input has index s.
- R5: A request whose own enable bit is low, or any request while the global enable is low, is never selected. It stays pending, and it is selected once enabled.
- R6: The interrupt output and the vector index appear one clock after the request is evaluated. While the interrupt output is high and acknowledge is low, both hold steady, even if the requests change.
- R7: An acknowledge while the interrupt output is high sets the in-service bit of the granted level. It also drops the interrupt output on the next clock.
- R8: While any level is in service, only a request with a level strictly above the highest in-service level is raised. Requests at an equal or lower level wait.
- R9: A return-from-interrupt pulse clears the highest set in-service bit and leaves the lower bits set.
- R10: After reset the interrupt output is low, the vector index is zero and no level is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 12 | Pending request lines, one per source |
| en_i | input | 12 | Per-source enable bits |
| glb_en_i | input | 1 | Global interrupt enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on address) |
| ack_i | input | 1 | Core accepts the presented interrupt |
| reti_i | input | 1 | Core returns from the current handler |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 4 | Index of the selected source |

## Verification
The bench builds the block with its defaults: six groups of two sources, which makes twelve request lines. At this size every one of the 4096 request patterns can be swept under several priority settings, including all-equal levels, distinct levels and an irregular mix. This covers the level comparison and the full polling order. Enable masks and the global enable are swept the same way. Short directed sequences then step the in-service vector through nested preemption, equal-level blocking and clearing of the highest bit, and they check that the register port ignores the unused bits.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 4;

  typedef logic [LVL_W-1:0]   lvl_t;
  typedef logic [NUM_LVL-1:0] isr_t;

  // Highest set bit of an in-service vector (0 when empty).
  function automatic lvl_t isr_top(input isr_t v);
    lvl_t r;
    r = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (v[l]) r = lvl_t'(l);
    end
    return r;
  endfunction

  // One-hot mask of the highest set bit of an in-service vector.
  function automatic isr_t isr_top_mask(input isr_t v);
    isr_t m;
    m = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (v[l]) m = isr_t'(1) << l;
    end
    return m;
  endfunction

endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs #(
  parameter int NUM_GROUPS = 6,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'hA9,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'hB9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [NUM_GROUPS-1:0] lo_o,
  output logic [NUM_GROUPS-1:0] hi_o
);

  logic [NUM_GROUPS-1:0] lo_q, lo_d, hi_q, hi_d;
  logic                  lo_en, hi_en;

  assign lo_en = we_i && (addr_i == LO_ADDR);
  assign hi_en = we_i && (addr_i == HI_ADDR);

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (lo_en) lo_d = wdata_i[NUM_GROUPS-1:0];
    if (hi_en) hi_d = wdata_i[NUM_GROUPS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == LO_ADDR)      rdata_o[NUM_GROUPS-1:0] = lo_q;
    else if (addr_i == HI_ADDR) rdata_o[NUM_GROUPS-1:0] = hi_q;
  end

  generate
    if (NUM_GROUPS < DATA_W) begin : g_spare
      logic unused_wbits;
      assign unused_wbits = ^wdata_i[DATA_W-1:NUM_GROUPS];
    end
  endgenerate

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  assert_lo_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == LO_ADDR) |=> lo_q == $past(wdata_i[NUM_GROUPS-1:0]));

  assert_hi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && addr_i == HI_ADDR) |=> $stable(hi_q));

endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_prio_pkg::*;
#(
  parameter int NUM_GROUPS  = 6,
  parameter int SRC_PER_GRP = 2,
  localparam int NSRC       = NUM_GROUPS * SRC_PER_GRP,
  localparam int VEC_W      = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]       req_i,
  input  logic [NSRC-1:0]       en_i,
  input  logic                  glb_en_i,
  input  logic [NUM_GROUPS-1:0] lo_i,
  input  logic [NUM_GROUPS-1:0] hi_i,
  input  logic                  busy_i,
  input  lvl_t                  busy_lvl_i,
  output logic                  found_o,
  output logic [VEC_W-1:0]      idx_o,
  output lvl_t                  lvl_o
);

  lvl_t            src_lvl [NSRC];
  logic [NSRC-1:0] elig;

  genvar gs;
  generate
    for (gs = 0; gs < NSRC; gs++) begin : g_src
      localparam int GRP = gs / SRC_PER_GRP;
      assign src_lvl[gs] = {hi_i[GRP], lo_i[GRP]};
      assign elig[gs]    = req_i[gs] && en_i[gs] && glb_en_i &&
                           (!busy_i || (src_lvl[gs] > busy_lvl_i));
    end
  endgenerate

  // Ascending scan; strict compare keeps the earliest source on ties.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (elig[s] && (!found_o || (src_lvl[s] > lvl_o))) begin
        found_o = 1'b1;
        idx_o   = VEC_W'(s);
        lvl_o   = src_lvl[s];
      end
    end
  end

endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
  import irq_prio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ack_fire_i,
  input  lvl_t ack_lvl_i,
  input  logic reti_i,
  output logic busy_o,
  output lvl_t busy_lvl_o
);

  isr_t isr_q, isr_d;

  always_comb begin
    isr_d = isr_q;
    if (reti_i)     isr_d = isr_d & ~isr_top_mask(isr_q);
    if (ack_fire_i) isr_d[ack_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  assign busy_o     = |isr_q;
  assign busy_lvl_o = isr_top(isr_q);

  assert_ack_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire_i && !reti_i) |=> isr_q[$past(ack_lvl_i)]);

  assert_reti_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !ack_fire_i && |isr_q) |=>
      ($countones(isr_q) == $past($countones(isr_q)) - 1) &&
      ((isr_q & $past(isr_q)) == isr_q));

endmodule

// File: rtl/irq_prioritizer.sv
module irq_prioritizer
  import irq_prio_pkg::*;
#(
  parameter int NUM_GROUPS  = 6,
  parameter int SRC_PER_GRP = 2,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'hA9,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'hB9,
  localparam int NSRC       = NUM_GROUPS * SRC_PER_GRP,
  localparam int VEC_W      = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_i,
  input  logic [NSRC-1:0]   en_i,
  input  logic              glb_en_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              ack_i,
  input  logic              reti_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o
);

  logic [NUM_GROUPS-1:0] lo_w, hi_w;
  logic                  busy, found;
  lvl_t                  busy_lvl, sel_lvl;
  logic [VEC_W-1:0]      sel_idx;

  logic                  irq_q, irq_d;
  logic [VEC_W-1:0]      vec_q, vec_d;
  lvl_t                  lvl_q, lvl_d;
  logic                  ack_fire;

  irq_prio_regs #(
    .NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .lo_o(lo_w), .hi_o(hi_w)
  );

  irq_select #(
    .NUM_GROUPS(NUM_GROUPS), .SRC_PER_GRP(SRC_PER_GRP)
  ) sel_i (
    .req_i(req_i), .en_i(en_i), .glb_en_i(glb_en_i), .lo_i(lo_w), .hi_i(hi_w),
    .busy_i(busy), .busy_lvl_i(busy_lvl),
    .found_o(found), .idx_o(sel_idx), .lvl_o(sel_lvl)
  );

  assign ack_fire = irq_q && ack_i;

  irq_inservice isr_i (
    .clk(clk), .rst_n(rst_n), .ack_fire_i(ack_fire), .ack_lvl_i(lvl_q),
    .reti_i(reti_i), .busy_o(busy), .busy_lvl_o(busy_lvl)
  );

  always_comb begin
    irq_d = irq_q;
    vec_d = vec_q;
    lvl_d = lvl_q;
    if (irq_q) begin
      if (ack_i) irq_d = 1'b0;
    end else begin
      irq_d = found;
      if (found) begin
        vec_d = sel_idx;
        lvl_d = sel_lvl;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      vec_q <= '0;
      lvl_q <= '0;
    end else begin
      irq_q <= irq_d;
      vec_q <= vec_d;
      lvl_q <= lvl_d;
    end
  end

  assign irq_o = irq_q;
  assign vec_o = vec_q;

  assert_vec_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_i) |=> (irq_o && $stable(vec_o)));

  assert_ack_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_i) |=> !irq_o);

  assert_preempt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (!busy || (lvl_q > busy_lvl)));

  assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !glb_en_i) |=> !irq_o);

endmodule

// File: tb/irq_prioritizer_tb_top.sv
module irq_prioritizer_tb_top;

  localparam int NG   = 6;
  localparam int NS   = 12;
  localparam int VW   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] req = '0;
  logic [NS-1:0] en = '0;
  logic          gen = 1'b0;
  logic          we = 1'b0;
  logic [7:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          ack = 1'b0;
  logic          reti = 1'b0;
  logic          irq;
  logic [VW-1:0] vec;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [NG-1:0] m_lo, m_hi;

  always #4 clk = ~clk;

  irq_prioritizer dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .en_i(en), .glb_en_i(gen),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ack_i(ack), .reti_i(reti), .irq_o(irq), .vec_o(vec)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
    if (a == 8'hA9) m_lo = d[NG-1:0];
    if (a == 8'hB9) m_hi = d[NG-1:0];
  endtask

  // Expected winner: returns -1 when none, else source index.
  function automatic int model(input logic [NS-1:0] r, input logic [NS-1:0] e,
                               input logic g, input int busy_top);
    int best, bl;
    best = -1; bl = -1;
    for (int s = 0; s < NS; s++) begin
      int l;
      l = 2 * int'(m_hi[s/2]) + int'(m_lo[s/2]);
      if (r[s] && e[s] && g && l > busy_top && l > bl) begin
        best = s; bl = l;
      end
    end
    return best;
  endfunction

  // Present a pattern from idle, check, then unwind to idle.
  task automatic sweep_one(input string tag, input logic [NS-1:0] r,
                           input logic [NS-1:0] e, input logic g);
    int w;
    req = r; en = e; gen = g;
    step();
    w = model(r, e, g, -1);
    check(tag, irq ? int'(vec) : -1, w);
    if (irq) begin
      ack = 1'b1;
      step();
      ack = 1'b0; reti = 1'b1; req = '0;
      step();
      reti = 1'b0;
    end
  endtask

  task automatic raise_ack(input int src, input string tag, input int exp_vec);
    req = '0; req[src] = 1'b1;
    step();
    check(tag, irq ? int'(vec) : -1, exp_vec);
    if (irq) begin
      ack = 1'b1;
      step();
      ack = 1'b0;
      req = '0;
      check("R7 irq drops after ack", int'(irq), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_lo = '0; m_hi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 irq after reset", int'(irq), 0);
    check("R10 vec after reset", int'(vec), 0);
    addr = 8'hA9; #1;
    check("R10 R2 lo reg after reset", int'(rdata), 0);

    // R2 register port
    wr(8'hA9, 8'hFF);
    addr = 8'hA9; #1;
    check("R2 lo reg reads 0x3F", int'(rdata), 8'h3F);
    wr(8'hB9, 8'hC5);
    addr = 8'hB9; #1;
    check("R2 hi reg reads 0x05", int'(rdata), 8'h05);
    wr(8'h55, 8'hFF);
    addr = 8'h55; #1;
    check("R2 other addr reads 0", int'(rdata), 0);
    addr = 8'hB9; #1;
    check("R2 hi reg untouched", int'(rdata), 8'h05);

    // R3 R4 R1: config all equal -> pure polling order
    wr(8'hA9, 8'h00); wr(8'hB9, 8'h00);
    for (int p = 0; p < 4096; p++) sweep_one("R4 polling sweep", NS'(p), '1, 1'b1);

    // R1 R3: distinct levels per group
    wr(8'hA9, 8'b010110); wr(8'hB9, 8'b100011);
    for (int p = 0; p < 4096; p++) sweep_one("R1 R3 level sweep", NS'(p), '1, 1'b1);

    // R5: enable mask sweep with mixed levels
    wr(8'hA9, 8'b101001); wr(8'hB9, 8'b011010);
    for (int p = 0; p < 4096; p++)
      sweep_one("R5 enable sweep", NS'(p * 37 + 5), NS'(p), 1'b1);
    for (int p = 0; p < 256; p++) sweep_one("R5 global off", NS'(p * 16 + 3), '1, 1'b0);

    // R5 pending kept: disabled request then enabled
    req = NS'(1 << 7); en = '0; gen = 1'b1;
    step(); step();
    check("R5 disabled not raised", int'(irq), 0);
    en = '1;
    step();
    check("R5 pending raised once enabled", irq ? int'(vec) : -1, 7);

    // R6 hold while unacknowledged
    req = NS'(1 << 0);
    step(); step();
    check("R6 vec held", int'(vec), 7);
    check("R6 irq held", int'(irq), 1);
    ack = 1'b1; step(); ack = 1'b0; req = '0;
    reti = 1'b1; step(); reti = 1'b0;

    // R8 R9 nesting: group0 L0, group1 L1, group2 L2, group3 L3
    wr(8'hA9, 8'b001010); wr(8'hB9, 8'b001100);
    raise_ack(2, "R8 level1 from idle", 2);
    req = NS'(1 << 3);
    step();
    check("R8 equal level waits", int'(irq), 0);
    req = NS'(1 << 0);
    step();
    check("R8 lower level waits", int'(irq), 0);
    raise_ack(6, "R8 level3 preempts", 6);
    req = NS'(1 << 4);
    step();
    check("R8 level2 blocked under level3", int'(irq), 0);
    req = '0;
    reti = 1'b1; step(); reti = 1'b0;
    req = NS'(1 << 4);
    step();
    check("R9 highest cleared, level2 now preempts", irq ? int'(vec) : -1, 4);
    ack = 1'b1; step(); ack = 1'b0; req = '0;
    reti = 1'b1; step();
    req = NS'(1 << 3);
    step();
    reti = 1'b0;
    check("R9 level1 still in service", int'(irq), 0);
    req = '0;
    reti = 1'b1; step(); reti = 1'b0;
    req = NS'(1 << 0);
    step();
    check("R9 all cleared, level0 raised", irq ? int'(vec) : -1, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule